// File: doc/BRIEF.md
# Field-Rate Auto Exposure Sequencer

This block closes the exposure loop of a camera once per field. A metering front end streams one low-pass averaged luminance value for each of 48 picture sections. The block weights those values so that the middle of the picture counts most, and reduces them to a single evaluation level. It then compares that level with a programmable target and moves exactly one exposure actuator by one step. The four actuators are the iris aperture code, the AGC gain code, the shutter mode and an auto-light lamp enable.

The actuators form a fixed ladder. From brightest to darkest the rungs are: fast shutter, iris, AGC, slow shutter, lamp. Too much light walks down the ladder and too little light walks up it. The slow-shutter rung doubles exposure time, so entering it takes back a programmable number of AGC codes (one 6 dB step) in the same update, and leaving it gives them back. The lamp has separate on and off levels, so it does not hunt. While AGC carries part of the correction, the target is lowered by a programmable relief amount, which keeps noise down. Iris and gain codes stay inside programmable limits.

Top module: `ae_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to: shutter normal (code 0), gain equal to `gain_lo`, iris equal to (`iris_lo`+`iris_hi`)/2 rounded down, lamp off, `upd_done` low.
- R2: Sections arrive on `sec_vld` in row-major order, column fastest, over 8 columns by 6 rows. With column distance dc=min(c,7-c) and row distance dr=min(r,5-r), the weight of a section is 2 + {0,1,3,4}[dc] + {0,1,3}[dr]. The weights sum to 256, so the evaluation level is the weighted sum shifted right by 8. `upd_done` is high for exactly one cycle, on the clock edge after the edge that captures the 48th section. All actuator outputs change only on that edge.
- R3: With effective target T and deadband D, a field is bright when level > T+D and dark when level+D < T. Otherwise nothing changes.
- R4: On a bright field the block takes the first rung that can move, in this order: lamp (see R7); lower gain by 1 if it is above `gain_lo`; leave slow shutter to normal and raise gain by the slow step, clamped at `gain_hi`; close the iris by 1 if it is above `iris_lo`.
- R5: On a dark field the block takes the first rung that can move, in this order: open the iris by 1 if it is below `iris_hi`; leave fast shutter (R6); raise gain by 1 if it is below `gain_hi`; from normal shutter, enter slow shutter (code 1). Slow shutter is entered only with gain at `gain_hi`, and gain then drops by the slow step (default 6 codes), clamped at `gain_lo`.
- R6: A bright field with normal shutter, gain at `gain_lo` and iris at `iris_lo` selects fast shutter (code 2) and reopens the iris by the reopen step (default 8), clamped at `iris_hi`. A dark field in fast shutter with iris at `iris_hi` returns to normal shutter and closes the iris by the reopen step, clamped at `iris_lo`.
- R7: The lamp turns on only on a dark field with slow shutter, gain at `gain_hi` and level < `lamp_on_lvl`. While the lamp is on, a bright field turns it off only when level > `lamp_off_lvl`; otherwise nothing moves.
- R8: The effective target is `tgt_level` minus `tgt_relief` (floored at 0) whenever gain is above `gain_lo` or slow shutter is active. Otherwise it is `tgt_level`.
- R9: Iris and gain codes never leave [`iris_lo`,`iris_hi`] and [`gain_lo`,`gain_hi`], including the multi-code steps of R4, R5 and R6.
- R10: One update moves at most one rung. Iris and gain change by 1, except where a shutter change carries its paired step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_vld | input | 1 | Section value valid |
| sec_luma | input | 8 | Section average luminance |
| tgt_level | input | 8 | Exposure target |
| tgt_relief | input | 8 | Target reduction while AGC is engaged |
| dead_band | input | 8 | Half-width of the no-change band |
| lamp_on_lvl | input | 8 | Lamp switches on below this level |
| lamp_off_lvl | input | 8 | Lamp switches off above this level |
| iris_lo | input | 6 | Smallest iris code |
| iris_hi | input | 6 | Largest iris code |
| gain_lo | input | 6 | Smallest gain code |
| gain_hi | input | 6 | Largest gain code |
| iris_code | output | 6 | Iris aperture code |
| gain_code | output | 6 | AGC gain code |
| shutter_mode | output | 2 | 0 normal, 1 slow, 2 fast |
| lamp_en | output | 1 | Auto-light enable |
| upd_done | output | 1 | One-cycle pulse per evaluated field |

## Verification
The hardest states to reach are the two ends of the ladder: the lamp rung with its hysteresis hold, and fast-shutter entry followed by the walk back out. Both are reached only after tens of consecutive fields push every lower rung to its limit. The bench gets there by streaming long runs of uniform fields, where the level equals the section value, and checks the state at each rung boundary. Uniform fields cannot separate the weights, so single-section and centre-quad patterns are measured against a target of a few codes.

// File: rtl/ae_pkg.sv
// Package: shared types and the section weight map for the exposure sequencer.
// Assumes an 8x6 section grid delivered row-major, column fastest.
package ae_pkg;

    localparam int GRID_COLS = 8;
    localparam int GRID_ROWS = 6;
    localparam int SECTIONS  = GRID_COLS * GRID_ROWS;
    localparam int WEIGHT_W  = 4;

    typedef enum logic [1:0] {
        SHUT_NORMAL = 2'd0,
        SHUT_SLOW   = 2'd1,
        SHUT_FAST   = 2'd2
    } shutter_e;

    // Weight grows with closeness to the picture centre on both axes.
    function automatic logic [WEIGHT_W-1:0] sect_weight(input int col, input int row);
        int dc;
        int dr;
        int cw;
        int rw;
        dc = (col < GRID_COLS / 2) ? col : GRID_COLS - 1 - col;
        dr = (row < GRID_ROWS / 2) ? row : GRID_ROWS - 1 - row;
        cw = (dc == 0) ? 0 : (dc == 1) ? 1 : (dc == 2) ? 3 : 4;
        rw = (dr == 0) ? 0 : (dr == 1) ? 1 : 3;
        return WEIGHT_W'(2 + cw + rw);
    endfunction

    // Sum of all weights, used to normalise the weighted total.
    function automatic int weight_total();
        int s;
        s = 0;
        for (int r = 0; r < GRID_ROWS; r++)
            for (int c = 0; c < GRID_COLS; c++)
                s += int'(sect_weight(c, r));
        return s;
    endfunction

endpackage

// File: rtl/ae_meter.sv
// Module: weighted field meter. Accumulates weight*luma over one field of
// sections and emits the normalised level for one cycle after the last one.
// Assumes sections never skip; a reset realigns the section counter.
module ae_meter
    import ae_pkg::*;
#(
    parameter int LUMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [LUMA_W-1:0] smp_luma,
    output logic              eval_vld,
    output logic [LUMA_W-1:0] eval_luma
);
    localparam int COL_W   = $clog2(GRID_COLS);
    localparam int ROW_W   = $clog2(GRID_ROWS);
    localparam int ACC_W   = LUMA_W + WEIGHT_W + $clog2(SECTIONS);
    localparam int WSUM    = weight_total();
    localparam bit IS_POW2 = (WSUM & (WSUM - 1)) == 0;
    localparam int SHIFT   = $clog2(WSUM);

    logic [COL_W-1:0]    col_q;
    logic [ROW_W-1:0]    row_q;
    logic [ACC_W-1:0]    acc_q;
    logic [WEIGHT_W-1:0] wt;
    logic [ACC_W-1:0]    sum_next;
    logic [LUMA_W-1:0]   norm_next;
    logic                last_sec;

    // Weight lookup and running-sum for the current section.
    always_comb begin
        wt       = sect_weight(int'(col_q), int'(row_q));
        sum_next = acc_q + ACC_W'(smp_luma) * ACC_W'(wt);
        last_sec = (col_q == COL_W'(GRID_COLS - 1)) && (row_q == ROW_W'(GRID_ROWS - 1));
    end

    // Normalisation: shift when the weight total is a power of two, else divide.
    generate
        if (IS_POW2) begin : g_shift
            assign norm_next = LUMA_W'(sum_next >> SHIFT);
        end else begin : g_div
            assign norm_next = LUMA_W'(sum_next / ACC_W'(WSUM));
        end
    endgenerate

    // Section position, accumulator and level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q     <= '0;
            row_q     <= '0;
            acc_q     <= '0;
            eval_vld  <= 1'b0;
            eval_luma <= '0;
        end else begin
            eval_vld <= 1'b0;
            if (smp_vld) begin
                if (last_sec) begin
                    col_q     <= '0;
                    row_q     <= '0;
                    acc_q     <= '0;
                    eval_vld  <= 1'b1;
                    eval_luma <= norm_next;
                end else begin
                    acc_q <= sum_next;
                    if (col_q == COL_W'(GRID_COLS - 1)) begin
                        col_q <= '0;
                        row_q <= row_q + 1'b1;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
            end
        end
    end

    AST_EVAL_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        eval_vld |-> $past(smp_vld)); // R2

endmodule

// File: rtl/ae_ladder.sv
// Module: exposure ladder. On each evaluated field, compares the level with
// the effective target and moves the first movable rung by one step.
// Assumes limit inputs satisfy lo <= hi and change only between fields.
module ae_ladder
    import ae_pkg::*;
#(
    parameter int LUMA_W           = 8,
    parameter int IRIS_W           = 6,
    parameter int GAIN_W           = 6,
    parameter int SLOW_GAIN_STEP   = 6,
    parameter int FAST_IRIS_REOPEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_vld,
    input  logic [LUMA_W-1:0] eval_luma,
    input  logic [LUMA_W-1:0] tgt_level,
    input  logic [LUMA_W-1:0] tgt_relief,
    input  logic [LUMA_W-1:0] dead_band,
    input  logic [LUMA_W-1:0] lamp_on_lvl,
    input  logic [LUMA_W-1:0] lamp_off_lvl,
    input  logic [IRIS_W-1:0] iris_lo,
    input  logic [IRIS_W-1:0] iris_hi,
    input  logic [GAIN_W-1:0] gain_lo,
    input  logic [GAIN_W-1:0] gain_hi,
    output logic [IRIS_W-1:0] iris_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic [1:0]        shutter_mode,
    output logic              lamp_en,
    output logic              upd_done
);
    localparam int CW = LUMA_W + 2;
    localparam logic [IRIS_W:0] REOPEN_X = (IRIS_W + 1)'(FAST_IRIS_REOPEN);
    localparam logic [GAIN_W:0] SLOW_X   = (GAIN_W + 1)'(SLOW_GAIN_STEP);

    logic [IRIS_W-1:0] iris_q, iris_n, iris_open_r, iris_close_r;
    logic [GAIN_W-1:0] gain_q, gain_n, gain_raise_k, gain_drop_k;
    shutter_e          shut_q, shut_n;
    logic              lamp_q, lamp_n;
    logic              past_ok;
    logic [CW-1:0]     ev_x, db_x, t_eff;
    logic [IRIS_W:0]   iris_plus, iris_mid;
    logic [GAIN_W:0]   gain_plus;
    logic              bright, dark;

    // Effective target with AGC relief, and the bright/dark classification.
    always_comb begin
        ev_x = CW'(eval_luma);
        db_x = CW'(dead_band);
        if ((gain_q != gain_lo) || (shut_q == SHUT_SLOW))
            t_eff = (tgt_level > tgt_relief) ? CW'(tgt_level - tgt_relief) : '0;
        else
            t_eff = CW'(tgt_level);
        bright = ev_x > (t_eff + db_x);
        dark   = (ev_x + db_x) < t_eff;
    end

    // Saturating multi-code steps paired with shutter changes.
    always_comb begin
        iris_plus    = {1'b0, iris_q} + REOPEN_X;
        iris_open_r  = (iris_plus > {1'b0, iris_hi}) ? iris_hi : iris_plus[IRIS_W-1:0];
        iris_close_r = ({1'b0, iris_q} >= ({1'b0, iris_lo} + REOPEN_X))
                       ? iris_q - REOPEN_X[IRIS_W-1:0] : iris_lo;
        gain_plus    = {1'b0, gain_q} + SLOW_X;
        gain_raise_k = (gain_plus > {1'b0, gain_hi}) ? gain_hi : gain_plus[GAIN_W-1:0];
        gain_drop_k  = ({1'b0, gain_q} >= ({1'b0, gain_lo} + SLOW_X))
                       ? gain_q - SLOW_X[GAIN_W-1:0] : gain_lo;
        iris_mid     = ({1'b0, iris_lo} + {1'b0, iris_hi}) >> 1;
    end

    // Rung selection: first movable rung in ladder order for the error sign.
    always_comb begin
        iris_n = iris_q;
        gain_n = gain_q;
        shut_n = shut_q;
        lamp_n = lamp_q;
        if (bright) begin
            if (lamp_q) begin
                if (ev_x > CW'(lamp_off_lvl)) lamp_n = 1'b0;
            end else if (gain_q > gain_lo) begin
                gain_n = gain_q - 1'b1;
            end else if (shut_q == SHUT_SLOW) begin
                shut_n = SHUT_NORMAL;
                gain_n = gain_raise_k;
            end else if (iris_q > iris_lo) begin
                iris_n = iris_q - 1'b1;
            end else if (shut_q == SHUT_NORMAL) begin
                shut_n = SHUT_FAST;
                iris_n = iris_open_r;
            end
        end else if (dark) begin
            if (iris_q < iris_hi) begin
                iris_n = iris_q + 1'b1;
            end else if (shut_q == SHUT_FAST) begin
                shut_n = SHUT_NORMAL;
                iris_n = iris_close_r;
            end else if (gain_q < gain_hi) begin
                gain_n = gain_q + 1'b1;
            end else if (shut_q == SHUT_NORMAL) begin
                shut_n = SHUT_SLOW;
                gain_n = gain_drop_k;
            end else if (!lamp_q && (ev_x < CW'(lamp_on_lvl))) begin
                lamp_n = 1'b1;
            end
        end
    end

    // Actuator state, update strobe and the assertion history flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iris_q   <= iris_mid[IRIS_W-1:0];
            gain_q   <= gain_lo;
            shut_q   <= SHUT_NORMAL;
            lamp_q   <= 1'b0;
            upd_done <= 1'b0;
            past_ok  <= 1'b0;
        end else begin
            past_ok  <= 1'b1;
            upd_done <= eval_vld;
            if (eval_vld) begin
                iris_q <= iris_n;
                gain_q <= gain_n;
                shut_q <= shut_n;
                lamp_q <= lamp_n;
            end
        end
    end

    assign iris_code    = iris_q;
    assign gain_code    = gain_q;
    assign shutter_mode = shut_q;
    assign lamp_en      = lamp_q;

    AST_HOLD_BETWEEN_UPDATES: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !upd_done |-> ($stable(iris_q) && $stable(gain_q) && $stable(shut_q) && $stable(lamp_q))); // R2
    AST_SLOW_AT_MAX_GAIN: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (shut_q == SHUT_SLOW && $past(shut_q) == SHUT_NORMAL) |-> ($past(gain_q) == $past(gain_hi))); // R5
    AST_FAST_AT_MIN_IRIS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (shut_q == SHUT_FAST && $past(shut_q) == SHUT_NORMAL) |-> ($past(iris_q) == $past(iris_lo))); // R6
    AST_LAMP_ON_GUARD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $rose(lamp_q) |-> (shut_q == SHUT_SLOW && gain_q == gain_hi)); // R7
    AST_LAMP_MOVES_ALONE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$stable(lamp_q) |-> ($stable(iris_q) && $stable(gain_q) && $stable(shut_q))); // R10
    AST_ONE_CODE_RUNG: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $stable(shut_q) |-> ($stable(iris_q) || $stable(gain_q))); // R10

endmodule

// File: rtl/ae_sequencer.sv
// Module: top of the field-rate auto exposure sequencer. Joins the weighted
// meter to the actuator ladder. Assumes one field of 48 sections per update.
module ae_sequencer #(
    parameter int LUMA_W           = 8,
    parameter int IRIS_W           = 6,
    parameter int GAIN_W           = 6,
    parameter int SLOW_GAIN_STEP   = 6,
    parameter int FAST_IRIS_REOPEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_vld,
    input  logic [LUMA_W-1:0] sec_luma,
    input  logic [LUMA_W-1:0] tgt_level,
    input  logic [LUMA_W-1:0] tgt_relief,
    input  logic [LUMA_W-1:0] dead_band,
    input  logic [LUMA_W-1:0] lamp_on_lvl,
    input  logic [LUMA_W-1:0] lamp_off_lvl,
    input  logic [IRIS_W-1:0] iris_lo,
    input  logic [IRIS_W-1:0] iris_hi,
    input  logic [GAIN_W-1:0] gain_lo,
    input  logic [GAIN_W-1:0] gain_hi,
    output logic [IRIS_W-1:0] iris_code,
    output logic [GAIN_W-1:0] gain_code,
    output logic [1:0]        shutter_mode,
    output logic              lamp_en,
    output logic              upd_done
);
    logic              eval_vld;
    logic [LUMA_W-1:0] eval_luma;

    ae_meter #(.LUMA_W(LUMA_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (sec_vld),
        .smp_luma  (sec_luma),
        .eval_vld  (eval_vld),
        .eval_luma (eval_luma)
    );

    ae_ladder #(
        .LUMA_W           (LUMA_W),
        .IRIS_W           (IRIS_W),
        .GAIN_W           (GAIN_W),
        .SLOW_GAIN_STEP   (SLOW_GAIN_STEP),
        .FAST_IRIS_REOPEN (FAST_IRIS_REOPEN)
    ) u_ladder (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval_vld     (eval_vld),
        .eval_luma    (eval_luma),
        .tgt_level    (tgt_level),
        .tgt_relief   (tgt_relief),
        .dead_band    (dead_band),
        .lamp_on_lvl  (lamp_on_lvl),
        .lamp_off_lvl (lamp_off_lvl),
        .iris_lo      (iris_lo),
        .iris_hi      (iris_hi),
        .gain_lo      (gain_lo),
        .gain_hi      (gain_hi),
        .iris_code    (iris_code),
        .gain_code    (gain_code),
        .shutter_mode (shutter_mode),
        .lamp_en      (lamp_en),
        .upd_done     (upd_done)
    );

endmodule

// File: tb/test_ae_sequencer.sv
// Directed bench for the exposure sequencer: one task per scenario.
module test_ae_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_vld = 1'b0;
    logic [7:0] sec_luma = '0;
    logic [7:0] tgt_level = 8'd100, tgt_relief = 8'd10, dead_band = 8'd4;
    logic [7:0] lamp_on_lvl = 8'd40, lamp_off_lvl = 8'd120;
    logic [5:0] iris_lo = 6'd10, iris_hi = 6'd20, gain_lo = 6'd0, gain_hi = 6'd12;
    logic [5:0] iris_code, gain_code;
    logic [1:0] shutter_mode;
    logic       lamp_en, upd_done;

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk; // 125 MHz

    ae_sequencer i_ae_sequencer (
        .clk(clk), .rst_n(rst_n), .sec_vld(sec_vld), .sec_luma(sec_luma),
        .tgt_level(tgt_level), .tgt_relief(tgt_relief), .dead_band(dead_band),
        .lamp_on_lvl(lamp_on_lvl), .lamp_off_lvl(lamp_off_lvl),
        .iris_lo(iris_lo), .iris_hi(iris_hi), .gain_lo(gain_lo), .gain_hi(gain_hi),
        .iris_code(iris_code), .gain_code(gain_code), .shutter_mode(shutter_mode),
        .lamp_en(lamp_en), .upd_done(upd_done)
    );

    task automatic chk(input string req, input int ei, input int eg, input int es, input int el);
        checks++;
        if (iris_code != ei || gain_code != eg || shutter_mode != es || lamp_en != el) begin
            errs++;
            $display("FAIL %s: iris/gain/shut/lamp actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     req, iris_code, gain_code, shutter_mode, lamp_en, ei, eg, es, el);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sec_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Section value for pattern kind: 0 uniform, 1 spot at (sc,sr), 2 centre quad.
    function automatic logic [7:0] sec_val(input int kind, input int c, input int r,
                                           input int sc, input int sr, input logic [7:0] v);
        if (kind == 0) return v;
        if (kind == 1) return (c == sc && r == sr) ? v : 8'd0;
        return ((c == 3 || c == 4) && (r == 2 || r == 3)) ? v : 8'd0;
    endfunction

    // Stream one field row-major, then wait for the update strobe.
    task automatic field(input int kind, input logic [7:0] v, input int sc = 0, input int sr = 0);
        bit seen;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                sec_vld  = 1'b1;
                sec_luma = sec_val(kind, c, r, sc, sr, v);
            end
        @(negedge clk);
        sec_vld = 1'b0;
        seen = 0;
        for (int k = 0; k < 4 && !seen; k++) begin
            @(negedge clk);
            if (upd_done) seen = 1;
        end
        if (!seen) begin
            checks++;
            errs++;
            $display("FAIL R2: update strobe actual 0 expected 1");
        end
    endtask

    task automatic fields(input int n, input logic [7:0] v);
        for (int i = 0; i < n; i++) field(0, v);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset state", 15, 0, 0, 0);
        chk_bit("R1 done low", upd_done, 1'b0);
    endtask

    task automatic t_strobe();
        field(0, 8'd100);
        chk("R2 strobe field holds", 15, 0, 0, 0);
        @(negedge clk);
        chk_bit("R2 strobe one cycle", upd_done, 1'b0);
    endtask

    task automatic t_deadband();
        field(0, 8'd103); chk("R3 inside band high", 15, 0, 0, 0);
        field(0, 8'd96);  chk("R3 edge of band low", 15, 0, 0, 0);
        field(0, 8'd104); chk("R3 edge of band high", 15, 0, 0, 0);
        field(0, 8'd105); chk("R4 bright closes iris", 14, 0, 0, 0);
        field(0, 8'd95);  chk("R5 dark opens iris", 15, 0, 0, 0);
    endtask

    task automatic t_weights();
        do_reset();
        tgt_level = 8'd8; dead_band = 8'd0;
        field(1, 8'd255, 3, 2); chk("R2 centre spot level 8", 15, 0, 0, 0);
        field(1, 8'd255, 0, 0); chk("R2 corner spot level 1", 16, 0, 0, 0);
        tgt_level = 8'd35;
        field(2, 8'd255);       chk("R2 centre quad level 35", 16, 0, 0, 0);
        tgt_level = 8'd34;
        field(2, 8'd255);       chk("R2 centre quad above 34", 15, 0, 0, 0);
        tgt_level = 8'd1;
        field(1, 8'd255, 7, 5); chk("R2 far corner level 1", 15, 0, 0, 0);
        tgt_level = 8'd100; dead_band = 8'd4;
    endtask

    task automatic t_dark_ladder();
        do_reset();
        field(0, 8'd20); chk("R10 single iris step", 16, 0, 0, 0);
        fields(4, 8'd20); chk("R5 iris opened to max", 20, 0, 0, 0);
        fields(1, 8'd20); chk("R5 gain after iris", 20, 1, 0, 0);
        fields(11, 8'd20); chk("R5 no slow before max gain", 20, 12, 0, 0);
        fields(1, 8'd20); chk("R5 slow entry drops gain", 20, 6, 1, 0);
        fields(6, 8'd20); chk("R5 gain back to max", 20, 12, 1, 0);
        fields(1, 8'd20); chk("R7 lamp on", 20, 12, 1, 1);
        fields(1, 8'd20); chk("R7 top of ladder holds", 20, 12, 1, 1);
    endtask

    task automatic t_lamp_hyst();
        field(0, 8'd100); chk("R7 hysteresis hold", 20, 12, 1, 1);
        field(0, 8'd130); chk("R7 lamp off above level", 20, 12, 1, 0);
        field(0, 8'd100); chk("R4 gain lowered after lamp", 20, 11, 1, 0);
    endtask

    task automatic t_bright_ladder();
        fields(11, 8'd200); chk("R4 gain to min in slow", 20, 0, 1, 0);
        fields(1, 8'd200);  chk("R4 leave slow adds gain", 20, 6, 0, 0);
        fields(6, 8'd200);  chk("R4 gain to min", 20, 0, 0, 0);
        fields(10, 8'd200); chk("R4 iris to min", 10, 0, 0, 0);
        fields(1, 8'd200);  chk("R6 fast entry reopens iris", 18, 0, 2, 0);
        fields(8, 8'd200);  chk("R4 iris closes in fast", 10, 0, 2, 0);
        fields(1, 8'd200);  chk("R9 bottom of ladder holds", 10, 0, 2, 0);
    endtask

    task automatic t_leave_fast();
        fields(10, 8'd20); chk("R5 iris open in fast", 20, 0, 2, 0);
        fields(1, 8'd20);  chk("R6 leave fast closes iris", 12, 0, 0, 0);
        fields(8, 8'd20);  chk("R5 iris reopened", 20, 0, 0, 0);
        fields(1, 8'd20);  chk("R5 gain raised", 20, 1, 0, 0);
        field(0, 8'd92);   chk("R8 relief target holds", 20, 1, 0, 0);
        field(0, 8'd98);   chk("R8 relief target bright", 20, 0, 0, 0);
        field(0, 8'd98);   chk("R8 full target holds", 20, 0, 0, 0);
    endtask

    task automatic t_saturation();
        iris_lo = 6'd10; iris_hi = 6'd14; gain_lo = 6'd2; gain_hi = 6'd5;
        do_reset();
        chk("R1 reset with new limits", 12, 2, 0, 0);
        fields(2, 8'd200); chk("R9 iris at low limit", 10, 2, 0, 0);
        fields(1, 8'd200); chk("R9 fast reopen clamped", 14, 2, 2, 0);
        fields(1, 8'd20);  chk("R6 leave fast clamped", 10, 2, 0, 0);
        fields(4, 8'd20);  chk("R5 iris max", 14, 2, 0, 0);
        fields(3, 8'd20);  chk("R9 gain at high limit", 14, 5, 0, 0);
        fields(1, 8'd20);  chk("R9 slow drop clamped", 14, 2, 1, 0);
        fields(1, 8'd200); chk("R4 leave slow", 14, 5, 0, 0);
        iris_lo = 6'd10; iris_hi = 6'd20; gain_lo = 6'd0; gain_hi = 6'd12;
    endtask

    initial begin
        t_reset();
        t_strobe();
        t_deadband();
        t_weights();
        t_dark_ladder();
        t_lamp_hyst();
        t_bright_ladder();
        t_leave_fast();
        t_saturation();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule